// File: doc/BRIEF.md
# Flash Linear Read Window

This block lets a bus master read a serial flash device as if it were ordinary memory. Software sets up a read-operation word in the phase format used by the serial transfer engine, a base flash address, a window length and a control word. The control word carries a primary opcode, a second opcode, a target select and an enable bit. Once the window is enabled, each read on the memory port at byte offset `o` inside the window starts a four-byte serial read of flash address `base + o`. The block passes the latched phase settings to a downstream phase sequencer and returns the fetched word.

Reads that arrive while the window is disabled, or at an offset at or beyond the programmed length, complete at once with data 0 and an error flag. Software disarms the window by clearing the enable bit. If an access is in flight, the disarm waits until that access completes. The disarm then sets a sticky status flag that software clears by writing a one to it. A mask register chooses which status bits are reported on reads and on the interrupt line.

Top module: `flash_read_window`

## Requirements
- R1: After a synchronous reset, every register reads 0, and `mem_ready`, `seq_req` and `irq` are 0.
- R2: The registers read back what was written. The read-operation word is at 0x44, the control word at 0x48, the base address at 0x4C, the length at 0x50 and the mask at 0x08. A register read returns data on `reg_rdata` one cycle after `reg_re`.
- R3: The control word has these fields: bit 31 is the enable, bits 7:0 the primary opcode, bits 15:8 the second opcode, and bits 21 and up (TW bits) the target. An in-window access raises `seq_req` one cycle after `mem_valid`. At that point `seq_addr` equals base + offset (modulo 2^FAW), and `seq_opc0`, `seq_opc1`, `seq_target` and `seq_opcfg` equal the programmed values.
- R4: During a serial read, `mem_ready` stays low until the sequencer returns `seq_done`. In the next cycle `mem_ready` is high for exactly one cycle, with `mem_rdata` = `seq_rdata` and `mem_err` = 0.
- R5: An access at an offset >= length, or while the window is disabled, raises no `seq_req`. One cycle later it gives `mem_ready` = 1, `mem_err` = 1 and `mem_rdata` = 0.
- R6: Writing the control word with bit 31 = 0 while the window is enabled sets status bit 11 (offset 0x04). Writing 1 to bit 11 at 0x04 clears it. Writing 0 to bit 11 leaves it unchanged. Clearing a window that is already disabled does not set it.
- R7: A read of 0x04 returns the raw status ANDed with the mask at 0x08. `irq` is the OR of the masked status, registered one cycle later.
- R8: A disable written while an access is in flight (including in its launch cycle) leaves the control word's bit 31 reading 1 and the status at 0 until that access completes. At completion the window becomes disabled and status bit 11 is set.
- R9: If a deferred disable sets status bit 11 in the same cycle as a write-one-to-clear of that bit, the set wins.
- R10: The fields on the sequencer request stay constant while `seq_req` is high, even if the registers are rewritten.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe |
| reg_addr | input | RAW | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, one cycle after reg_re |
| irq | output | 1 | OR of masked status |
| mem_valid | input | 1 | Memory read request, held until mem_ready |
| mem_addr | input | MAW | Byte offset inside the window |
| mem_ready | output | 1 | One-cycle completion pulse |
| mem_rdata | output | 32 | Read data |
| mem_err | output | 1 | Access was not serviced |
| seq_req | output | 1 | Serial read request, held until seq_done |
| seq_addr | output | FAW | Flash address of the read |
| seq_opcfg | output | 32 | Read-operation phase word |
| seq_opc0 | output | 8 | Primary opcode |
| seq_opc1 | output | 8 | Second opcode |
| seq_target | output | TW | Target select |
| seq_done | input | 1 | Sequencer completion pulse |
| seq_rdata | input | 32 | Four fetched bytes |

## Verification
Two functions can land in the same cycle: a deferred disable and the write-one-to-clear of the status flag. The bench first leaves the flag set. It then writes the disable in the launch cycle of a read whose sequencer latency is fixed, and places the clear write exactly on the edge where that read completes. It judges the result by reading the status afterwards, which must still show bit 11. A second overlap, a disable landing while the read is in flight, is judged by reading the control word and status mid-read and again after the data returns.

// File: rtl/frw_pkg.sv
package frw_pkg;
  localparam int DW = 32;

  localparam logic [7:0] OFF_STS  = 8'h04;
  localparam logic [7:0] OFF_MASK = 8'h08;
  localparam logic [7:0] OFF_CFG  = 8'h44;
  localparam logic [7:0] OFF_CTRL = 8'h48;
  localparam logic [7:0] OFF_BASE = 8'h4C;
  localparam logic [7:0] OFF_LEN  = 8'h50;

  localparam int CTRL_EN_BIT  = 31;
  localparam int CTRL_TGT_LSB = 21;
  localparam int STS_OFF_BIT  = 11;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_RESP  = 2'd2
  } fsm_state_t;
endpackage

// File: rtl/frw_regs.sv
module frw_regs
  import frw_pkg::*;
#(
  parameter int RAW = 8,
  parameter int FAW = 32,
  parameter int TW  = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           reg_we,
  input  logic           reg_re,
  input  logic [RAW-1:0] reg_addr,
  input  logic [DW-1:0]  reg_wdata,
  output logic [DW-1:0]  reg_rdata,
  output logic           irq,
  input  logic           hold,
  input  logic           done,
  output logic           win_en,
  output logic [DW-1:0]  op_cfg,
  output logic [7:0]     opc0,
  output logic [7:0]     opc1,
  output logic [TW-1:0]  target,
  output logic [FAW-1:0] base,
  output logic [DW-1:0]  win_len
);
  localparam int PADW = CTRL_EN_BIT - CTRL_TGT_LSB - TW;

  logic          en_q, pend_q, sts_q;
  logic [DW-1:0] mask_q;
  logic          wr_ctrl, wr_sts, clr_req, dis_now;
  logic [DW-1:0] sts_vec, sts_masked, ctrl_view, rd_mux;

  assign wr_ctrl = reg_we && (reg_addr == RAW'(OFF_CTRL));
  assign wr_sts  = reg_we && (reg_addr == RAW'(OFF_STS));
  assign clr_req = wr_ctrl && !reg_wdata[CTRL_EN_BIT] && en_q;
  // A disable applies now unless a read is still outstanding.
  assign dis_now = (clr_req && (!hold || done)) || (pend_q && done);

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= 1'b0;
      pend_q <= 1'b0;
      sts_q  <= 1'b0;
    end else begin
      if (dis_now)
        en_q <= 1'b0;
      else if (wr_ctrl && reg_wdata[CTRL_EN_BIT])
        en_q <= 1'b1;

      if (wr_ctrl)
        pend_q <= clr_req && hold && !done;
      else if (done)
        pend_q <= 1'b0;

      // Set has priority over write-one-to-clear.
      if (dis_now)
        sts_q <= 1'b1;
      else if (wr_sts && reg_wdata[STS_OFF_BIT])
        sts_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      op_cfg  <= '0;
      opc0    <= '0;
      opc1    <= '0;
      target  <= '0;
      base    <= '0;
      win_len <= '0;
      mask_q  <= '0;
    end else if (reg_we) begin
      case (reg_addr)
        RAW'(OFF_CFG):  op_cfg  <= reg_wdata;
        RAW'(OFF_BASE): base    <= reg_wdata[FAW-1:0];
        RAW'(OFF_LEN):  win_len <= reg_wdata;
        RAW'(OFF_MASK): mask_q  <= reg_wdata;
        RAW'(OFF_CTRL): begin
          opc0   <= reg_wdata[7:0];
          opc1   <= reg_wdata[15:8];
          target <= reg_wdata[CTRL_TGT_LSB +: TW];
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    sts_vec              = '0;
    sts_vec[STS_OFF_BIT] = sts_q;
    sts_masked           = sts_vec & mask_q;
    ctrl_view = {en_q, {PADW{1'b0}}, target, 5'b0, opc1, opc0};
    case (reg_addr)
      RAW'(OFF_STS):  rd_mux = sts_masked;
      RAW'(OFF_MASK): rd_mux = mask_q;
      RAW'(OFF_CFG):  rd_mux = op_cfg;
      RAW'(OFF_CTRL): rd_mux = ctrl_view;
      RAW'(OFF_BASE): rd_mux = DW'(base);
      RAW'(OFF_LEN):  rd_mux = win_len;
      default:        rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
      irq       <= 1'b0;
    end else begin
      if (reg_re) reg_rdata <= rd_mux;
      irq <= |sts_masked;
    end
  end

  assign win_en = en_q;
endmodule

// File: rtl/frw_fetch.sv
module frw_fetch
  import frw_pkg::*;
#(
  parameter int MAW = 16,
  parameter int FAW = 32,
  parameter int TW  = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           win_en,
  input  logic [DW-1:0]  op_cfg,
  input  logic [7:0]     opc0,
  input  logic [7:0]     opc1,
  input  logic [TW-1:0]  target,
  input  logic [FAW-1:0] base,
  input  logic [DW-1:0]  win_len,
  input  logic           mem_valid,
  input  logic [MAW-1:0] mem_addr,
  output logic           mem_ready,
  output logic [DW-1:0]  mem_rdata,
  output logic           mem_err,
  output logic           seq_req,
  output logic [FAW-1:0] seq_addr,
  output logic [DW-1:0]  seq_opcfg,
  output logic [7:0]     seq_opc0,
  output logic [7:0]     seq_opc1,
  output logic [TW-1:0]  seq_target,
  input  logic           seq_done,
  input  logic [DW-1:0]  seq_rdata,
  output logic           hold,
  output logic           done
);
  fsm_state_t state;
  logic       in_win, launch, reject;

  assign in_win = win_en && (DW'(mem_addr) < win_len);
  assign launch = (state == ST_IDLE) && mem_valid && in_win;
  assign reject = (state == ST_IDLE) && mem_valid && !in_win;
  assign hold   = launch || (state == ST_FETCH);
  assign done   = (state == ST_FETCH) && seq_done;

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      mem_ready  <= 1'b0;
      mem_rdata  <= '0;
      mem_err    <= 1'b0;
      seq_req    <= 1'b0;
      seq_addr   <= '0;
      seq_opcfg  <= '0;
      seq_opc0   <= '0;
      seq_opc1   <= '0;
      seq_target <= '0;
    end else begin
      mem_ready <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (launch) begin
            seq_req    <= 1'b1;
            seq_addr   <= base + FAW'(mem_addr);
            seq_opcfg  <= op_cfg;
            seq_opc0   <= opc0;
            seq_opc1   <= opc1;
            seq_target <= target;
            state      <= ST_FETCH;
          end else if (reject) begin
            mem_ready <= 1'b1;
            mem_rdata <= '0;
            mem_err   <= 1'b1;
            state     <= ST_RESP;
          end
        end
        ST_FETCH: begin
          if (seq_done) begin
            seq_req   <= 1'b0;
            mem_ready <= 1'b1;
            mem_rdata <= seq_rdata;
            mem_err   <= 1'b0;
            state     <= ST_RESP;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/flash_read_window.sv
module flash_read_window
  import frw_pkg::*;
#(
  parameter int RAW = 8,
  parameter int MAW = 16,
  parameter int FAW = 32,
  parameter int TW  = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           reg_we,
  input  logic           reg_re,
  input  logic [RAW-1:0] reg_addr,
  input  logic [31:0]    reg_wdata,
  output logic [31:0]    reg_rdata,
  output logic           irq,
  input  logic           mem_valid,
  input  logic [MAW-1:0] mem_addr,
  output logic           mem_ready,
  output logic [31:0]    mem_rdata,
  output logic           mem_err,
  output logic           seq_req,
  output logic [FAW-1:0] seq_addr,
  output logic [31:0]    seq_opcfg,
  output logic [7:0]     seq_opc0,
  output logic [7:0]     seq_opc1,
  output logic [TW-1:0]  seq_target,
  input  logic           seq_done,
  input  logic [31:0]    seq_rdata
);
  logic           win_en, hold, done;
  logic [DW-1:0]  op_cfg, win_len;
  logic [7:0]     opc0, opc1;
  logic [TW-1:0]  target;
  logic [FAW-1:0] base;

  frw_regs #(.RAW(RAW), .FAW(FAW), .TW(TW)) regs_i (
    .clk(clk), .rst(rst),
    .reg_we(reg_we), .reg_re(reg_re), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
    .hold(hold), .done(done),
    .win_en(win_en), .op_cfg(op_cfg), .opc0(opc0), .opc1(opc1),
    .target(target), .base(base), .win_len(win_len)
  );

  frw_fetch #(.MAW(MAW), .FAW(FAW), .TW(TW)) fetch_i (
    .clk(clk), .rst(rst),
    .win_en(win_en), .op_cfg(op_cfg), .opc0(opc0), .opc1(opc1),
    .target(target), .base(base), .win_len(win_len),
    .mem_valid(mem_valid), .mem_addr(mem_addr),
    .mem_ready(mem_ready), .mem_rdata(mem_rdata), .mem_err(mem_err),
    .seq_req(seq_req), .seq_addr(seq_addr), .seq_opcfg(seq_opcfg),
    .seq_opc0(seq_opc0), .seq_opc1(seq_opc1), .seq_target(seq_target),
    .seq_done(seq_done), .seq_rdata(seq_rdata),
    .hold(hold), .done(done)
  );
endmodule

// File: rtl/frw_checker.sv
module frw_checker #(
  parameter int FAW = 32
) (
  input logic           clk,
  input logic           rst,
  input logic           mem_ready,
  input logic           mem_err,
  input logic [31:0]    mem_rdata,
  input logic           seq_req,
  input logic           seq_done,
  input logic [FAW-1:0] seq_addr,
  input logic [7:0]     seq_opc0
);
  assert_ready_low_in_fetch_R4: assert property (@(posedge clk) disable iff (rst)
    seq_req |-> !mem_ready);

  assert_ready_single_pulse_R4: assert property (@(posedge clk) disable iff (rst)
    mem_ready |=> !mem_ready);

  assert_good_data_after_done_R4: assert property (@(posedge clk) disable iff (rst)
    (mem_ready && !mem_err) |-> $past(seq_done));

  assert_err_data_zero_R5: assert property (@(posedge clk) disable iff (rst)
    (mem_ready && mem_err) |-> (mem_rdata == 32'd0));

  assert_req_fields_stable_R10: assert property (@(posedge clk) disable iff (rst)
    seq_req |=> (!seq_req || ($stable(seq_addr) && $stable(seq_opc0))));
endmodule

bind flash_read_window frw_checker #(.FAW(FAW)) chk_i (
  .clk(clk), .rst(rst), .mem_ready(mem_ready), .mem_err(mem_err),
  .mem_rdata(mem_rdata), .seq_req(seq_req), .seq_done(seq_done),
  .seq_addr(seq_addr), .seq_opc0(seq_opc0)
);

// File: tb/flash_read_window_tb_top.sv
module flash_read_window_tb_top;
  localparam int RAW = 8, MAW = 16, FAW = 32, TW = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic           reg_we = 0, reg_re = 0;
  logic [RAW-1:0] reg_addr = '0;
  logic [31:0]    reg_wdata = '0, reg_rdata;
  logic           irq;
  logic           mem_valid = 0;
  logic [MAW-1:0] mem_addr = '0;
  logic           mem_ready, mem_err;
  logic [31:0]    mem_rdata;
  logic           seq_req;
  logic [FAW-1:0] seq_addr;
  logic [31:0]    seq_opcfg;
  logic [7:0]     seq_opc0, seq_opc1;
  logic [TW-1:0]  seq_target;
  logic           seq_done = 0;
  logic [31:0]    seq_rdata = '0;

  flash_read_window #(.RAW(RAW), .MAW(MAW), .FAW(FAW), .TW(TW)) dut_i (.*);

  int tests = 0, fails = 0;
  int seq_lat = 0;
  int seq_cnt = 0;

  function automatic logic [31:0] flash_word(logic [31:0] a);
    return a ^ 32'h5A3C_0F96;
  endfunction

  // Sequencer model: completes seq_lat negedges after first seeing seq_req.
  always @(negedge clk) begin
    if (seq_done) begin
      seq_done = 0;
      seq_cnt  = 0;
    end else if (seq_req) begin
      if (seq_cnt == seq_lat) begin
        seq_done  = 1;
        seq_rdata = flash_word(seq_addr);
        seq_cnt   = 0;
      end else seq_cnt = seq_cnt + 1;
    end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic reg_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 0;
  endtask

  task automatic reg_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_re = 1; reg_addr = a;
    @(negedge clk);
    reg_re = 0;
    d = reg_rdata;
  endtask

  // Expected request fields for in-window accesses.
  logic [31:0] e_cfg;
  logic [7:0]  e_opc0, e_opc1;
  logic [TW-1:0] e_tgt;

  task automatic mem_access(input int off, input bit exp_in,
                            input logic [31:0] exp_addr, input int lat);
    int w;
    seq_lat = lat;
    @(negedge clk);
    mem_valid = 1; mem_addr = MAW'(off);
    w = 0;
    for (int k = 0; k < 200; k++) begin
      @(negedge clk);
      w++;
      if (w == 1) begin
        check(seq_req == exp_in, "R3/R5 seq_req on access", 32'(seq_req), 32'(exp_in));
        if (exp_in) begin
          check(seq_addr == exp_addr, "R3 seq_addr", seq_addr, exp_addr);
          check(seq_opc0 == e_opc0 && seq_opc1 == e_opc1 && seq_target == e_tgt
                && seq_opcfg == e_cfg, "R3 request fields",
                {seq_opc1, seq_opc0, 14'b0, seq_target}, {e_opc1, e_opc0, 14'b0, e_tgt});
        end
      end
      if (mem_ready) break;
    end
    mem_valid = 0;
    if (exp_in) begin
      check(w == 2 + lat, "R4 ready cycle", 32'(w), 32'(2 + lat));
      check(!mem_err && mem_rdata == flash_word(exp_addr), "R4 read data",
            mem_rdata, flash_word(exp_addr));
    end else begin
      check(w == 1, "R5 reject cycle", 32'(w), 32'd1);
      check(mem_err && mem_rdata == 0, "R5 error data", {mem_err, mem_rdata[30:0]}, 32'h8000_0000);
    end
    @(negedge clk);
    check(!mem_ready, "R4 ready one cycle", 32'(mem_ready), 32'd0);
  endtask

  function automatic logic [31:0] ctrl_word(bit en, logic [7:0] o0, logic [7:0] o1,
                                            logic [TW-1:0] t);
    return (32'(en) << 31) | (32'(t) << 21) | (32'(o1) << 8) | 32'(o0);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] v;
    logic [31:0] bases[3];
    int lens[4];
    bases[0] = 32'h0; bases[1] = 32'h1000_0000; bases[2] = 32'hFFFF_FFFA;
    lens[0] = 0; lens[1] = 1; lens[2] = 5; lens[3] = 8;

    repeat (4) @(negedge clk);
    rst = 0;

    // R1 reset state
    check(!mem_ready && !seq_req && !irq, "R1 outputs after reset",
          {29'b0, mem_ready, seq_req, irq}, 32'd0);
    reg_read(8'h04, v); check(v == 0, "R1 status", v, 0);
    reg_read(8'h08, v); check(v == 0, "R1 mask", v, 0);
    reg_read(8'h44, v); check(v == 0, "R1 cfg", v, 0);
    reg_read(8'h48, v); check(v == 0, "R1 ctrl", v, 0);
    reg_read(8'h4C, v); check(v == 0, "R1 base", v, 0);
    reg_read(8'h50, v); check(v == 0, "R1 len", v, 0);

    // R2 readback; clearing an already-disabled window sets nothing (R6)
    reg_write(8'h08, 32'h0000_0800);
    reg_write(8'h44, 32'h0080_4A5A);
    reg_write(8'h4C, 32'h1234_5670);
    reg_write(8'h50, 32'd12);
    reg_write(8'h48, ctrl_word(0, 8'h6B, 8'h3C, 2'd3));
    reg_read(8'h08, v); check(v == 32'h800, "R2 mask readback", v, 32'h800);
    reg_read(8'h44, v); check(v == 32'h0080_4A5A, "R2 cfg readback", v, 32'h0080_4A5A);
    reg_read(8'h4C, v); check(v == 32'h1234_5670, "R2 base readback", v, 32'h1234_5670);
    reg_read(8'h50, v); check(v == 12, "R2 len readback", v, 12);
    reg_read(8'h48, v); check(v == ctrl_word(0, 8'h6B, 8'h3C, 2'd3), "R2 ctrl readback",
                              v, ctrl_word(0, 8'h6B, 8'h3C, 2'd3));
    reg_read(8'h04, v); check(v == 0, "R6 no set when already disabled", v, 0);

    // R5 disabled window rejects
    mem_access(0, 0, 0, 0);

    // Sweep: bases x lengths x offsets x latencies (R3 R4 R5)
    for (int b = 0; b < 3; b++) begin
      for (int l = 0; l < 4; l++) begin
        e_cfg  = 32'h00A0_0000 | 32'(b * 16 + l);
        e_opc0 = 8'h0B + 8'(l);
        e_opc1 = 8'hF0 - 8'(b);
        e_tgt  = TW'(b + l);
        reg_write(8'h44, e_cfg);
        reg_write(8'h4C, bases[b]);
        reg_write(8'h50, 32'(lens[l]));
        reg_write(8'h48, ctrl_word(1, e_opc0, e_opc1, e_tgt));
        for (int off = 0; off < 10; off++)
          mem_access(off, off < lens[l], bases[b] + 32'(off), off % 3);
      end
    end
    reg_read(8'h04, v); check(v == 0, "R6 re-enabling does not set status", v, 0);

    // R6 / R7 disable, clear, mask
    reg_write(8'h48, ctrl_word(0, 8'h03, 8'h00, 2'd0));
    reg_read(8'h04, v); check(v == 32'h800, "R6 disable sets bit 11", v, 32'h800);
    check(irq == 1, "R7 irq with mask set", 32'(irq), 1);
    reg_read(8'h48, v); check(v[31] == 0, "R6 enable bit cleared", v, 0);
    mem_access(0, 0, 0, 0);
    reg_write(8'h04, 32'hFFFF_F7FF);
    reg_read(8'h04, v); check(v == 32'h800, "R6 writing 0 to bit 11 keeps it", v, 32'h800);
    reg_write(8'h08, 32'h0);
    reg_read(8'h04, v); check(v == 0, "R7 masked status reads 0", v, 0);
    @(negedge clk);
    check(irq == 0, "R7 irq masked", 32'(irq), 0);
    reg_write(8'h08, 32'h800);
    reg_read(8'h04, v); check(v == 32'h800, "R7 raw status held under mask", v, 32'h800);
    reg_write(8'h04, 32'h800);
    reg_read(8'h04, v); check(v == 0, "R6 W1C clears", v, 0);
    @(negedge clk);
    check(irq == 0, "R7 irq after clear", 32'(irq), 0);

    // R8 disable during an in-flight access
    e_cfg = 32'h0000_1111; e_opc0 = 8'hEB; e_opc1 = 8'h14; e_tgt = 2'd1;
    reg_write(8'h44, e_cfg);
    reg_write(8'h4C, 32'h0000_4000);
    reg_write(8'h50, 32'd64);
    reg_write(8'h48, ctrl_word(1, e_opc0, e_opc1, e_tgt));
    fork
      mem_access(20, 1, 32'h0000_4014, 8);
      begin
        repeat (2) @(negedge clk);
        reg_write(8'h48, 32'h0);
        reg_read(8'h48, v); check(v == 32'h8000_0000, "R8 enable reads 1 mid-access", v, 32'h8000_0000);
        reg_read(8'h04, v); check(v == 0, "R8 status 0 mid-access", v, 0);
      end
    join
    reg_read(8'h48, v); check(v == 0, "R8 disabled after completion", v, 0);
    reg_read(8'h04, v); check(v == 32'h800, "R8 status set after completion", v, 32'h800);

    // R9 deferred set coincides with W1C (status already 1)
    reg_write(8'h48, ctrl_word(1, e_opc0, e_opc1, e_tgt));
    fork
      mem_access(4, 1, 32'h0000_4004, 4);
      begin
        reg_write(8'h48, ctrl_word(0, e_opc0, e_opc1, e_tgt));
        repeat (3) @(negedge clk);
        reg_write(8'h04, 32'h800);
      end
    join
    reg_read(8'h04, v); check(v == 32'h800, "R9 set wins over clear", v, 32'h800);
    reg_read(8'h48, v); check(v[31] == 0, "R9 window disabled", v, 0);
    reg_write(8'h04, 32'h800);
    reg_read(8'h04, v); check(v == 0, "R9 later clear works", v, 0);

    // R10 request fields frozen while rewriting registers
    reg_write(8'h48, ctrl_word(1, e_opc0, e_opc1, e_tgt));
    fork
      mem_access(8, 1, 32'h0000_4008, 9);
      begin
        repeat (2) @(negedge clk);
        reg_write(8'h4C, 32'h7777_0000);
        reg_write(8'h48, ctrl_word(1, 8'h99, 8'h88, 2'd2));
        @(negedge clk);
        check(seq_req && seq_addr == 32'h0000_4008 && seq_opc0 == e_opc0,
              "R10 fields held", seq_addr, 32'h0000_4008);
      end
    join

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule